// File: doc/BRIEF.md
# Receive Cell Admission Filter

This block sits on one receive link, between the incoming cell stream and the input port controller that consumes cells. Each cell arrives as a burst of words framed by start and end markers. Upstream logic marks the first word of every cell with two check results: a parity (BIP) mismatch flag and a sequence mismatch flag. For each cell the filter decides whether to pass it on unchanged or to drop it whole.

Three per-link control bits steer the decision. One inhibits dropping on parity errors and one inhibits dropping on sequence errors; each works on its own. A third bit disables the link for reception, so its cells are consumed and thrown away without being processed. The block raises a one-cycle drop pulse, with a cause vector, for every cell it drops because of an error check. It also keeps one saturating count per cause. A cause whose check is inhibited never drops a cell, never raises the pulse and never counts.

All outputs are registered and follow the input by one clock. The controls and the check flags are read only on the first word of a cell. A cell already in progress therefore always ends the way it started.

Top module: `rx_cell_filter`

## Requirements
- R1: A cell that arrives with both check flags clear, on an enabled link, is forwarded word for word. Each word appears on the outputs one clock after it is accepted, with its start and end markers kept.
- R2: A cell whose first word has `in_bip_err`=1 while `ctl_bip_inh`=0 is dropped: none of its words is forwarded. One clock after its last word is accepted, `drop_pulse` is 1 for one cycle and `drop_cause[0]` (parity cause) is 1.
- R3: A parity-flagged cell with `ctl_bip_inh`=1 and no active sequence cause is forwarded whole. It raises no `drop_pulse` and leaves `bip_drop_cnt` unchanged.
- R4: A cell whose first word has `in_seq_err`=1 while `ctl_seq_inh`=0 is dropped whole. One clock after its last word, `drop_pulse` is 1 and `drop_cause[1]` (sequence cause) is 1.
- R5: A sequence-flagged cell with `ctl_seq_inh`=1 and no active parity cause is forwarded whole. It raises no `drop_pulse` and leaves `seq_drop_cnt` unchanged.
- R6: A cell whose first word arrives while `ctl_rx_dis`=1 is discarded whatever its flags. It forwards nothing, raises no `drop_pulse` and changes no counter.
- R7: The control bits are sampled only on the first word of a cell. Changing them later in the cell does not alter that cell's outcome.
- R8: The check flags are sampled only on the first word of a cell. Their values on later words have no effect.
- R9: When a dropped cell's last word is accepted, `bip_drop_cnt` and `seq_drop_cnt` each increase by one if their own cause was active for that cell; both increase when both causes were active. The new value is visible one clock later. Each counter holds at all ones instead of wrapping.
- R10: While `rst` is high, and in the first cycle after it, `out_valid`, `drop_pulse`, `drop_cause` and both counters are 0.
- R11: `drop_pulse` and `out_valid` are never 1 in the same cycle. `drop_cause` is zero whenever `drop_pulse` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word present |
| in_sop | input | 1 | First word of a cell |
| in_eop | input | 1 | Last word of a cell |
| in_data | input | DATA_W | Cell word |
| in_bip_err | input | 1 | Parity check failed (read on first word) |
| in_seq_err | input | 1 | Sequence check failed (read on first word) |
| ctl_bip_inh | input | 1 | Inhibit parity-based dropping |
| ctl_seq_inh | input | 1 | Inhibit sequence-based dropping |
| ctl_rx_dis | input | 1 | Link disabled for reception |
| out_valid | output | 1 | Forwarded word present |
| out_sop | output | 1 | Forwarded first word |
| out_eop | output | 1 | Forwarded last word |
| out_data | output | DATA_W | Forwarded word |
| drop_pulse | output | 1 | One-cycle pulse per dropped cell |
| drop_cause | output | 2 | Bit 0 parity cause, bit 1 sequence cause |
| bip_drop_cnt | output | CNT_W | Saturating parity drop count |
| seq_drop_cnt | output | CNT_W | Saturating sequence drop count |

## Verification
Directed cells apply each error flag alone, then both together, under all four inhibit settings. This separates the two causes from each other and shows that one inhibit never masks the other's drop. Disabled-link cells with errors show that the disable bit bypasses both counting and the drop pulse. Cells whose controls and flags flip after the first word reveal any late sampling. Random cells with bubbles and lengths of one word upward cover single-word cells and gaps inside a cell, and a run of parity drops drives the counter into saturation.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  typedef enum logic [1:0] {
    ACT_IDLE = 2'd0,
    ACT_PASS = 2'd1,
    ACT_DROP = 2'd2,
    ACT_SKIP = 2'd3
  } cell_act_e;

  typedef struct packed {
    logic seq;
    logic bip;
  } drop_why_t;

  localparam int NUM_CAUSES = 2;
endpackage

// File: rtl/rxf_admit.sv
module rxf_admit
  import rxf_pkg::*;
(
  input  logic      bip_err,
  input  logic      seq_err,
  input  logic      bip_inh,
  input  logic      seq_inh,
  input  logic      rx_dis,
  output cell_act_e act,
  output drop_why_t why
);
  always_comb begin
    why     = '0;
    why.bip = bip_err & ~bip_inh & ~rx_dis;
    why.seq = seq_err & ~seq_inh & ~rx_dis;
    if (rx_dis)
      act = ACT_SKIP;
    else if (why.bip | why.seq)
      act = ACT_DROP;
    else
      act = ACT_PASS;
  end
endmodule

// File: rtl/rxf_sat_cnt.sv
module rxf_sat_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (rst)
      count <= '0;
    else if (inc && count != TOP)
      count <= count + 1'b1;
  end
endmodule

// File: rtl/rx_cell_filter.sv
module rx_cell_filter
  import rxf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_sop,
  input  logic              in_eop,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_bip_err,
  input  logic              in_seq_err,
  input  logic              ctl_bip_inh,
  input  logic              ctl_seq_inh,
  input  logic              ctl_rx_dis,
  output logic              out_valid,
  output logic              out_sop,
  output logic              out_eop,
  output logic [DATA_W-1:0] out_data,
  output logic              drop_pulse,
  output logic [1:0]        drop_cause,
  output logic [CNT_W-1:0]  bip_drop_cnt,
  output logic [CNT_W-1:0]  seq_drop_cnt
);
  cell_act_e adm_act, act_q, beat_act;
  drop_why_t adm_why, why_q, beat_why;
  logic      in_cell;
  logic      start;
  logic      cell_end;
  logic [NUM_CAUSES-1:0]            cnt_inc;
  logic [NUM_CAUSES-1:0][CNT_W-1:0] cnt_val;

  rxf_admit u_admit (
    .bip_err (in_bip_err),
    .seq_err (in_seq_err),
    .bip_inh (ctl_bip_inh),
    .seq_inh (ctl_seq_inh),
    .rx_dis  (ctl_rx_dis),
    .act     (adm_act),
    .why     (adm_why)
  );

  assign start    = in_valid & in_sop;
  assign cell_end = in_valid & in_eop;

  // Decision for the current word: fresh at a cell start, held otherwise.
  always_comb begin
    if (start) begin
      beat_act = adm_act;
      beat_why = adm_why;
    end else if (in_cell) begin
      beat_act = act_q;
      beat_why = why_q;
    end else begin
      beat_act = ACT_SKIP;
      beat_why = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      in_cell <= 1'b0;
      act_q   <= ACT_IDLE;
      why_q   <= '0;
    end else if (in_valid) begin
      if (start) begin
        act_q <= adm_act;
        why_q <= adm_why;
      end
      if (in_eop)
        in_cell <= 1'b0;
      else if (start)
        in_cell <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_sop    <= 1'b0;
      out_eop    <= 1'b0;
      out_data   <= '0;
      drop_pulse <= 1'b0;
      drop_cause <= '0;
    end else begin
      out_valid  <= in_valid & (beat_act == ACT_PASS);
      out_sop    <= in_valid & (beat_act == ACT_PASS) & in_sop;
      out_eop    <= in_valid & (beat_act == ACT_PASS) & in_eop;
      if (in_valid && beat_act == ACT_PASS)
        out_data <= in_data;
      drop_pulse <= cell_end & (beat_act == ACT_DROP);
      drop_cause <= (cell_end && beat_act == ACT_DROP) ? beat_why : 2'b00;
    end
  end

  assign cnt_inc[0] = cell_end & (beat_act == ACT_DROP) & beat_why.bip;
  assign cnt_inc[1] = cell_end & (beat_act == ACT_DROP) & beat_why.seq;

  for (genvar g = 0; g < NUM_CAUSES; g++) begin : g_cnt
    rxf_sat_cnt #(.W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst   (rst),
      .inc   (cnt_inc[g]),
      .count (cnt_val[g])
    );
  end

  assign bip_drop_cnt = cnt_val[0];
  assign seq_drop_cnt = cnt_val[1];
endmodule

// File: rtl/rxf_checker.sv
module rxf_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             out_valid,
  input logic             out_sop,
  input logic             out_eop,
  input logic             drop_pulse,
  input logic [1:0]       drop_cause,
  input logic [CNT_W-1:0] bip_drop_cnt,
  input logic [CNT_W-1:0] seq_drop_cnt
);
  // R11
  pulse_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(drop_pulse && out_valid));

  // R11
  cause_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !drop_pulse |-> drop_cause == 2'b00);

  // R2
  pulse_cause_chk: assert property (@(posedge clk) disable iff (rst)
    drop_pulse |-> drop_cause != 2'b00);

  // R1
  fwd_latency_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid));

  // R1
  marker_chk: assert property (@(posedge clk) disable iff (rst)
    (out_sop || out_eop) |-> out_valid);

  // R9
  bip_mono_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> bip_drop_cnt >= $past(bip_drop_cnt));

  // R9
  seq_mono_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> seq_drop_cnt >= $past(seq_drop_cnt));

  // R9
  bip_step_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(bip_drop_cnt) |-> (drop_pulse && drop_cause[0]));

  // R9
  seq_step_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(seq_drop_cnt) |-> (drop_pulse && drop_cause[1]));
endmodule

bind rx_cell_filter rxf_checker #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .in_valid     (in_valid),
  .out_valid    (out_valid),
  .out_sop      (out_sop),
  .out_eop      (out_eop),
  .drop_pulse   (drop_pulse),
  .drop_cause   (drop_cause),
  .bip_drop_cnt (bip_drop_cnt),
  .seq_drop_cnt (seq_drop_cnt)
);

// File: tb/rx_cell_filter_tb.sv
module rx_cell_filter_tb;
  localparam int DW = 32;
  localparam int CW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 0, in_sop = 0, in_eop = 0;
  logic [DW-1:0] in_data = '0;
  logic in_bip_err = 0, in_seq_err = 0;
  logic ctl_bip_inh = 0, ctl_seq_inh = 0, ctl_rx_dis = 0;
  logic out_valid, out_sop, out_eop, drop_pulse;
  logic [DW-1:0] out_data;
  logic [1:0] drop_cause;
  logic [CW-1:0] bip_drop_cnt, seq_drop_cnt;

  int checks = 0;
  int errors = 0;
  int exp_bcnt = 0, exp_scnt = 0;

  // monitor state
  int mon_n = 0, mon_sops = 0, mon_eops = 0, mon_pulses = 0;
  logic mon_first_sop = 0, mon_last_eop = 0;
  logic [1:0] mon_cause = '0;
  logic [DW-1:0] mon_dat [0:63];

  always #5 clk = ~clk;

  rx_cell_filter #(.DATA_W(DW), .CNT_W(CW)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop),
    .in_data(in_data), .in_bip_err(in_bip_err), .in_seq_err(in_seq_err),
    .ctl_bip_inh(ctl_bip_inh), .ctl_seq_inh(ctl_seq_inh), .ctl_rx_dis(ctl_rx_dis),
    .out_valid(out_valid), .out_sop(out_sop), .out_eop(out_eop), .out_data(out_data),
    .drop_pulse(drop_pulse), .drop_cause(drop_cause),
    .bip_drop_cnt(bip_drop_cnt), .seq_drop_cnt(seq_drop_cnt)
  );

  always @(negedge clk) begin
    if (out_valid) begin
      if (mon_n == 0) mon_first_sop = out_sop;
      if (mon_n < 64) mon_dat[mon_n] = out_data;
      mon_n++;
      mon_last_eop = out_eop;
      if (out_sop) mon_sops++;
      if (out_eop) mon_eops++;
    end
    if (drop_pulse) begin
      mon_pulses++;
      mon_cause = mon_cause | drop_cause;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int sat_inc(input int v);
    return (v >= (1 << CW) - 1) ? v : v + 1;
  endfunction

  task automatic mon_clear();
    mon_n = 0; mon_sops = 0; mon_eops = 0; mon_pulses = 0;
    mon_first_sop = 0; mon_last_eop = 0; mon_cause = '0;
  endtask

  // Sends one cell and checks its outcome. flip: controls and flags change after word 0.
  task automatic run_cell(input int len, input bit bip, input bit seq, input bit binh,
                          input bit sinh, input bit dis, input bit flip, input bit bubbles,
                          input string req);
    logic [DW-1:0] base;
    bit bd, sd, drop, pass;
    base = $urandom;
    bd = bip & ~binh & ~dis;
    sd = seq & ~sinh & ~dis;
    drop = bd | sd;
    pass = ~dis & ~drop;
    @(negedge clk);
    mon_clear();
    for (int i = 0; i < len; i++) begin
      if (bubbles && i > 0 && ($urandom % 4 == 0)) begin
        in_valid = 0; in_sop = 0; in_eop = 0;
        @(negedge clk);
      end
      in_valid = 1;
      in_sop = (i == 0);
      in_eop = (i == len - 1);
      in_data = base + DW'(i);
      if (i == 0) begin
        in_bip_err = bip; in_seq_err = seq;
        ctl_bip_inh = binh; ctl_seq_inh = sinh; ctl_rx_dis = dis;
      end else if (flip) begin
        // R7 R8: late changes must not matter
        in_bip_err = ~bip; in_seq_err = ~seq;
        ctl_bip_inh = ~binh; ctl_seq_inh = ~sinh; ctl_rx_dis = ~dis;
      end else begin
        in_bip_err = $urandom % 2; in_seq_err = $urandom % 2;
      end
      @(negedge clk);
    end
    in_valid = 0; in_sop = 0; in_eop = 0;
    in_bip_err = 0; in_seq_err = 0;
    ctl_bip_inh = 0; ctl_seq_inh = 0; ctl_rx_dis = 0;
    @(negedge clk);
    @(negedge clk);
    #1;
    if (bd) exp_bcnt = sat_inc(exp_bcnt);
    if (sd) exp_scnt = sat_inc(exp_scnt);
    check(mon_n == (pass ? len : 0), {req, " words"}, mon_n, pass ? len : 0);
    if (pass) begin
      for (int i = 0; i < len && i < 64; i++)
        check(mon_dat[i] == base + DW'(i), {req, " data"}, mon_dat[i], base + DW'(i));
      check(mon_first_sop && mon_last_eop && mon_sops == 1 && mon_eops == 1,
            {req, " markers"}, mon_sops * 10 + mon_eops, 11);
    end
    check(mon_pulses == (drop ? 1 : 0), {req, " pulses"}, mon_pulses, drop ? 1 : 0);
    check(mon_cause == {sd, bd}, {req, " cause"}, mon_cause, {sd, bd});
    check(bip_drop_cnt == CW'(exp_bcnt), {req, " R9 bip count"}, bip_drop_cnt, exp_bcnt);
    check(seq_drop_cnt == CW'(exp_scnt), {req, " R9 seq count"}, seq_drop_cnt, exp_scnt);
  endtask

  initial begin
    #1500000;
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20241));
    repeat (3) @(negedge clk);
    // R10: during reset
    check(!out_valid && !drop_pulse && drop_cause == 0 && bip_drop_cnt == 0 && seq_drop_cnt == 0,
          "R10 in reset", {out_valid, drop_pulse}, 0);
    rst = 0;
    @(negedge clk);
    check(!out_valid && !drop_pulse && bip_drop_cnt == 0 && seq_drop_cnt == 0,
          "R10 after reset", {out_valid, drop_pulse}, 0);

    run_cell(4, 0, 0, 0, 0, 0, 0, 0, "R1 clean");
    run_cell(1, 0, 0, 0, 0, 0, 0, 0, "R1 single word");
    run_cell(5, 1, 0, 0, 0, 0, 0, 0, "R2 bip drop");
    run_cell(5, 1, 0, 1, 0, 0, 0, 0, "R3 bip inhibited");
    run_cell(3, 0, 1, 0, 0, 0, 0, 0, "R4 seq drop");
    run_cell(3, 0, 1, 0, 1, 0, 0, 0, "R5 seq inhibited");
    run_cell(4, 1, 1, 0, 0, 0, 0, 0, "R9 both causes");
    run_cell(4, 1, 1, 1, 0, 0, 0, 0, "R4 seq with bip inhibited");
    run_cell(4, 1, 1, 0, 1, 0, 0, 0, "R2 bip with seq inhibited");
    run_cell(4, 1, 1, 1, 1, 0, 0, 0, "R3 R5 both inhibited");
    run_cell(4, 1, 1, 0, 0, 1, 0, 0, "R6 disabled");
    run_cell(2, 0, 0, 0, 0, 1, 0, 0, "R6 disabled clean");
    run_cell(6, 0, 0, 0, 0, 0, 1, 0, "R7 R8 late flip clean");
    run_cell(6, 1, 0, 0, 0, 0, 1, 0, "R7 late flip drop");
    run_cell(6, 0, 0, 1, 1, 1, 1, 0, "R7 late enable");
    // R9 saturation
    for (int k = 0; k < 20; k++)
      run_cell(1, 1, 0, 0, 0, 0, 0, 0, "R9 saturate");
    check(bip_drop_cnt == '1, "R9 held at max", bip_drop_cnt, (1 << CW) - 1);
    for (int k = 0; k < 150; k++)
      run_cell(1 + ($urandom % 8), $urandom % 2, $urandom % 2, $urandom % 2,
               $urandom % 2, ($urandom % 6) == 0, $urandom % 2, 1, "R1 random");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule